// File: doc/BRIEF.md
# I2C Target Front End for a Data-Converter Chip

This block is the serial-bus face of a small data-converter chip. It watches the two bus lines on a fast system clock, finds start and stop conditions, checks the 7-bit target address, and moves bytes between the bus and the converter's registers. It drives the data line through a single pull-low enable, which makes an open-drain output.

In a write, the position of a byte fixes where it lands. The first byte after the address goes to the control register. Every later byte goes to the DAC register and raises a one-cycle update strobe. In a read, each byte sent is the conversion result that was held before that byte was loaded. The block pulses a conversion-start output at the end of each acknowledge clock. This happens after the address and after each byte that the master acknowledges, so the next conversion runs while the current byte is shifted out. The converter hands its result back through a done/data pair.

Top module: `i2ct_front`

## Requirements
- R1: While reset is high, and in the cycle after it, the control and DAC registers read 0x00, the SDA pull-low enable is off, and neither the DAC strobe nor the conversion trigger is active.
- R2: The target responds to an address byte whose upper four bits are 1001 and whose next three bits equal the address pins (pin bit 2 first). The last bit selects the direction (0 = write, 1 = read). The target acknowledges by pulling SDA low through the ninth clock, and does the same after every byte it receives while addressed.
- R3: An address byte that does not match gets no acknowledge. All following bytes are ignored, with no acknowledge and no register change, until the next start condition.
- R4: The first byte written after the address is stored in the control register and does not raise the DAC strobe.
- R5: Each later byte of the same write is stored in the DAC register with exactly one single-cycle strobe per byte. The DAC register changes only in a strobe cycle.
- R6: A stop or a repeated start ends a write. The first byte of the next write goes to the control register again. A byte that is cut short by a stop is discarded.
- R7: In a read, a single-cycle conversion trigger is issued while SCL is low, at the falling edge of the acknowledge clock. This happens once after the address and once after every byte the master acknowledges.
- R8: Each read byte is sent MSB first and is the result held from the previous conversion. The first byte read after reset is 0x80. SDA changes only while SCL is low.
- R9: When the master does not acknowledge a read byte, the target releases SDA, issues no trigger, and keeps SDA released until the next stop or start.
- R10: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A start immediately followed by a stop changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | 3 | Hardware-strapped low address bits |
| conv_done_i | input | 1 | Converter result valid, one cycle |
| conv_data_i | input | 8 | Converter result, captured when done is high |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| ctrl_o | output | 8 | Control register contents |
| dac_o | output | 8 | DAC register contents |
| dac_we_o | output | 1 | One-cycle strobe when dac_o is written |
| conv_start_o | output | 1 | One-cycle conversion trigger |

## Verification
The checker assumes that the master holds each SCL low phase and high phase for at least six system clocks. With that margin, every change the block makes to SDA, and every trigger pulse, lands while the raw SCL is still low, even after the synchroniser delay. It also assumes that the master never issues a start or stop while the target is pulling SDA low.

The bench master uses four-cycle quarter periods, which gives low and high phases of eight cycles. It always releases SDA before a start or stop. The converter model answers each trigger one cycle later with a value the bench computes from the trigger count.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int BYTE_W = 8;
    localparam int PIN_W  = 3;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-PIN_W-2:0] FIXED_ADDR   = 4'b1001;
    localparam logic [BYTE_W-1:0]       RESULT_RESET = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } xfer_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // Address bits above the direction bit compared with fixed part and pins
    function automatic logic addr_hit(input logic [BYTE_W-2:0] a,
                                      input logic [PIN_W-1:0]  pins);
        return (a[BYTE_W-2:PIN_W] == FIXED_ADDR) && (a[PIN_W-1:0] == pins);
    endfunction

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync
    import i2ct_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_raw,
    input  logic    sda_raw,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_raw};
            sda_q <= {sda_q[STAGES-2:0], sda_raw};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/i2ct_reg_route.sv
module i2ct_reg_route #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_valid,
    input  logic         wr_to_ctrl,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q,
    output logic [W-1:0] dac_q,
    output logic         dac_we
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            dac_q  <= '0;
            dac_we <= 1'b0;
        end else begin
            dac_we <= 1'b0;
            if (wr_valid) begin
                if (wr_to_ctrl) begin
                    ctrl_q <= wr_data;
                end else begin
                    dac_q  <= wr_data;
                    dac_we <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2ct_result_hold.sv
module i2ct_result_hold #(
    parameter int           W         = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         res_valid,
    input  logic [W-1:0] res_data,
    output logic [W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= RESET_VAL;
        end else if (res_valid) begin
            held <= res_data;
        end
    end

endmodule

// File: rtl/i2ct_front.sv
module i2ct_front
    import i2ct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  addr_pins_i,
    input  logic              conv_done_i,
    input  logic [BYTE_W-1:0] conv_data_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] dac_o,
    output logic              dac_we_o,
    output logic              conv_start_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bus_ev_t           ev;
    xfer_state_e       state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] sh_in;
    logic [BYTE_W-1:0] held;
    logic              rw;
    logic              ack_on;
    logic              first_wr;
    logic              mack;
    logic              sda_oe_q;
    logic              conv_q;
    logic              wr_valid;
    logic              wr_to_ctrl;
    logic [BYTE_W-1:0] wr_data;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .ev      (ev)
    );

    i2ct_result_hold #(.W(BYTE_W), .RESET_VAL(RESULT_RESET)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .res_valid (conv_done_i),
        .res_data  (conv_data_i),
        .held      (held)
    );

    i2ct_reg_route #(.W(BYTE_W)) u_route (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_to_ctrl (wr_to_ctrl),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_o),
        .dac_q      (dac_o),
        .dac_we     (dac_we_o)
    );

    assign sh_in = {shreg[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            rw         <= 1'b0;
            ack_on     <= 1'b0;
            first_wr   <= 1'b1;
            mack       <= 1'b0;
            sda_oe_q   <= 1'b0;
            conv_q     <= 1'b0;
            wr_valid   <= 1'b0;
            wr_to_ctrl <= 1'b0;
            wr_data    <= '0;
        end else begin
            wr_valid <= 1'b0;
            conv_q   <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                ack_on   <= 1'b0;
                sda_oe_q <= 1'b0;
                first_wr <= 1'b1;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                ack_on   <= 1'b0;
                sda_oe_q <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (ev.rise) begin
                            shreg  <= sh_in;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                if (addr_hit(sh_in[BYTE_W-1:1], addr_pins_i)) begin
                                    rw    <= sh_in[0];
                                    state <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (ev.fall) begin
                            if (!ack_on) begin
                                ack_on   <= 1'b1;
                                sda_oe_q <= 1'b1;
                            end else begin
                                ack_on <= 1'b0;
                                bitcnt <= '0;
                                if (state == ST_ADDR_ACK && rw) begin
                                    shreg    <= held;
                                    sda_oe_q <= ~held[BYTE_W-1];
                                    conv_q   <= 1'b1;
                                    state    <= ST_RD_BYTE;
                                end else begin
                                    sda_oe_q <= 1'b0;
                                    state    <= ST_WR_BYTE;
                                end
                            end
                        end
                    end
                    ST_WR_BYTE: begin
                        if (ev.rise) begin
                            shreg  <= sh_in;
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) begin
                                wr_valid   <= 1'b1;
                                wr_to_ctrl <= first_wr;
                                wr_data    <= sh_in;
                                first_wr   <= 1'b0;
                                state      <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (ev.fall) begin
                            if (bitcnt == LAST_BIT) begin
                                sda_oe_q <= 1'b0;
                                state    <= ST_RD_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_q <= ~shreg[BYTE_W-2];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (mack) begin
                                shreg    <= held;
                                sda_oe_q <= ~held[BYTE_W-1];
                                conv_q   <= 1'b1;
                                bitcnt   <= '0;
                                state    <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign sda_oe_o     = sda_oe_q;
    assign conv_start_o = conv_q;

endmodule

// File: rtl/i2ct_front_chk.sv
module i2ct_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [7:0] ctrl_o,
    input logic [7:0] dac_o,
    input logic       dac_we_o,
    input logic       conv_start_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_o == 8'h00 && dac_o == 8'h00 && !sda_oe_o
                        && !conv_start_o && !dac_we_o));

    // R7
    conv_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o);

    // R7
    conv_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> !scl_i);

    // R5
    dac_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        dac_we_o |=> !dac_we_o);

    // R5
    dac_change_strobed_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_o) |-> dac_we_o);

    // R4
    ctrl_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_o) |-> !dac_we_o);

    // R8
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);

endmodule

bind i2ct_front i2ct_front_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .sda_oe_o     (sda_oe_o),
    .ctrl_o       (ctrl_o),
    .dac_o        (dac_o),
    .dac_we_o     (dac_we_o),
    .conv_start_o (conv_start_o)
);

// File: tb/sim_i2ct_front.sv
`timescale 1ns/1ps
module sim_i2ct_front;

    localparam int Q        = 4;
    localparam int WD_LIMIT = 150000;
    localparam int NVEC     = 6;
    // {pins[2:0], control byte, dac byte}
    localparam logic [18:0] WR_VEC [NVEC] = '{
        {3'b000, 8'h00, 8'hFF},
        {3'b101, 8'h44, 8'h01},
        {3'b111, 8'h7F, 8'h80},
        {3'b010, 8'hA5, 8'h5A},
        {3'b001, 8'h30, 8'hC3},
        {3'b110, 8'h05, 8'h7E}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'b000;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = 8'h00;
    logic       sda_oe;
    logic [7:0] ctrl;
    logic [7:0] dac;
    logic       dac_we;
    logic       conv_start;
    logic       sda_bus;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int conv_n = 0;
    int we_n = 0;
    bit done = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2ct_front u0 (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .addr_pins_i  (pins),
        .conv_done_i  (conv_done),
        .conv_data_i  (conv_data),
        .sda_oe_o     (sda_oe),
        .ctrl_o       (ctrl),
        .dac_o        (dac),
        .dac_we_o     (dac_we),
        .conv_start_o (conv_start)
    );

    function automatic logic [7:0] res_of(input int k);
        return 8'((60 + 17 * k) % 256);
    endfunction

    // converter model and strobe counting
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst && conv_start) begin
            conv_done <= 1'b1;
            conv_data <= res_of(conv_n);
            conv_n    <= conv_n + 1;
        end
        if (!rst && dac_we) we_n <= we_n + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=<%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl = 1'b1;   wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;  wq();
        scl = 1'b1; wq();
        s = sda_bus; wq();
        scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    initial begin
        logic       ack;
        logic       s;
        logic [7:0] rd;
        int         we0;
        int         cv0;

        repeat (5) @(posedge clk);
        #1;
        rst = 1'b0;
        wq();

        // R1: reset state
        chk("R1 ctrl", {24'h0, ctrl}, 32'h00);
        chk("R1 dac", {24'h0, dac}, 32'h00);
        chk("R1 sda_oe", {31'h0, sda_oe}, 32'h0);

        // R2 R4 R5: table of writes
        for (int v = 0; v < NVEC; v++) begin
            pins = WR_VEC[v][18:16];
            we0 = we_n;
            bus_start();
            write_byte({4'b1001, WR_VEC[v][18:16], 1'b0}, ack);
            chk("R2 address ack", {31'h0, ack}, 32'h1);
            write_byte(WR_VEC[v][15:8], ack);
            chk("R4 control byte stored", {24'h0, ctrl}, {24'h0, WR_VEC[v][15:8]});
            chk("R4 no dac strobe on control byte", we_n, we0);
            write_byte(WR_VEC[v][7:0], ack);
            chk("R2 data ack", {31'h0, ack}, 32'h1);
            bus_stop();
            chk("R5 dac byte stored", {24'h0, dac}, {24'h0, WR_VEC[v][7:0]});
            chk("R5 one strobe", we_n, we0 + 1);
        end

        // R5: several DAC bytes in one write
        pins = 3'b011;
        we0 = we_n;
        bus_start();
        write_byte(8'b1001_011_0, ack);
        write_byte(8'h45, ack);
        write_byte(8'h11, ack);
        write_byte(8'h22, ack);
        write_byte(8'h33, ack);
        bus_stop();
        chk("R5 last dac byte", {24'h0, dac}, 32'h33);
        chk("R5 three strobes", we_n, we0 + 3);
        chk("R5 control kept", {24'h0, ctrl}, 32'h45);

        // R3: wrong pins, then wrong fixed part
        pins = 3'b010;
        we0 = we_n;
        bus_start();
        write_byte(8'b1001_011_0, ack);
        chk("R3 no ack on pin mismatch", {31'h0, ack}, 32'h0);
        write_byte(8'hEE, ack);
        chk("R3 no ack on ignored byte", {31'h0, ack}, 32'h0);
        write_byte(8'hDD, ack);
        bus_stop();
        bus_start();
        write_byte(8'b1011_010_0, ack);
        chk("R3 no ack on fixed-part mismatch", {31'h0, ack}, 32'h0);
        write_byte(8'h99, ack);
        bus_stop();
        chk("R3 control untouched", {24'h0, ctrl}, 32'h45);
        chk("R3 dac untouched", {24'h0, dac}, 32'h33);
        chk("R3 no strobe", we_n, we0);

        // R6: repeated start restarts byte routing
        bus_start();
        write_byte(8'b1001_010_0, ack);
        write_byte(8'h12, ack);
        write_byte(8'h77, ack);
        bus_start();
        write_byte(8'b1001_010_0, ack);
        chk("R6 ack after repeated start", {31'h0, ack}, 32'h1);
        write_byte(8'h34, ack);
        bus_stop();
        chk("R6 first byte after repeated start to control", {24'h0, ctrl}, 32'h34);
        chk("R6 dac kept", {24'h0, dac}, 32'h77);

        // R6: stop inside a byte discards it
        we0 = we_n;
        bus_start();
        write_byte(8'b1001_010_0, ack);
        write_byte(8'h56, ack);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        clk_bit(1'b1, s);
        clk_bit(1'b0, s);
        bus_stop();
        chk("R6 control from whole byte", {24'h0, ctrl}, 32'h56);
        chk("R6 partial byte discarded", {24'h0, dac}, 32'h77);
        chk("R6 no strobe for partial byte", we_n, we0);

        // R10: start then stop changes nothing
        bus_start();
        bus_stop();
        chk("R10 control after start-stop", {24'h0, ctrl}, 32'h56);
        chk("R10 sda released", {31'h0, sda_oe}, 32'h0);

        // R7 R8 R9: reads
        cv0 = conv_n;
        bus_start();
        write_byte(8'b1001_010_1, ack);
        chk("R2 read address ack", {31'h0, ack}, 32'h1);
        wq();
        chk("R7 trigger after address", conv_n, cv0 + 1);
        read_byte(1'b1, rd);
        chk("R8 first read after reset", {24'h0, rd}, 32'h80);
        read_byte(1'b1, rd);
        chk("R8 previous conversion", {24'h0, rd}, {24'h0, res_of(cv0)});
        read_byte(1'b0, rd);
        chk("R8 previous conversion 2", {24'h0, rd}, {24'h0, res_of(cv0 + 1)});
        wq();
        chk("R7 R9 trigger count after nack", conv_n, cv0 + 3);
        clk_bit(1'b1, s);
        chk("R9 sda released after nack", {31'h0, s}, 32'h1);
        clk_bit(1'b1, s);
        chk("R9 sda still released", {31'h0, s}, 32'h1);
        bus_stop();

        bus_start();
        write_byte(8'b1001_010_1, ack);
        read_byte(1'b0, rd);
        bus_stop();
        chk("R8 next read returns last conversion", {24'h0, rd}, {24'h0, res_of(cv0 + 2)});
        chk("R7 one trigger for address only", conv_n, cv0 + 4);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule